// File: doc/BRIEF.md
# Misaligned Access Splitter

This block sits between an internal bus master and an external memory bus. The master issues one single, non-burst read or write at a time. The request names a start byte address and a length of one to four bytes. The block breaks the request into the fewest external accesses that stay naturally aligned, and issues them one after another in rising address order. Each external access carries a per-lane enable mask that marks exactly the requested bytes. The master gets a single completion only after the last external access is acknowledged. For reads, that completion carries the bytes already reassembled into operand order.

The external port runs as 32 bits wide (lanes 0..3) or 16 bits wide (lanes 0..1), chosen by a static input. Lanes use big-endian numbering: lane 0 is the most significant byte of the bus. A byte whose address has offset `o` within its container always travels on lane `o`.

A second, independent path screens accesses that arrive from the external side. Any misaligned one is answered with an error pulse and is not forwarded inward.

Top module: `misalign_split`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1 and `ext_start`, `rsp_valid`, `inb_err` and `inb_fwd` are all 0.
- R2: A request is taken when `req_valid` and `req_ready` are both 1, with length `req_len`+1 bytes (`req_len` 0..3). `req_ready` stays 0 from the next cycle until the completion, so only one request is ever outstanding.
- R3: On a 32-bit port (`port16`=0), bytes are grouped by aligned 4-byte word, and one access is issued per word touched, in ascending address order. Each access uses the smallest natural container that covers its bytes. The `ext_size` codes are 0 = byte (any address), 1 = halfword (address bit 0 clear) and 2 = word (address bits 1:0 clear). `ext_addr` is the container's start address.
- R4: On a 16-bit port (`port16`=1), bytes are grouped by aligned halfword, and every access is a byte or a halfword. Only lanes 0 and 1 are used, so a 4-byte aligned word goes out as two halfwords, the upper-address half last.
- R5: During an access, `ext_we` bit i is 1 exactly for the lanes that carry requested bytes, where lane i is the byte at container offset i. On writes, lane i sits on `ext_wdata[31-8i -: 8]` and carries operand byte k for address `req_addr`+k. Operand byte k is taken from `req_wdata[8*(len-k) +: 8]`, where len = `req_len`, so the operand is right-justified and most significant byte first. Inactive lanes are 0, and request bytes above the length are ignored.
- R6: On reads, each requested byte is taken from its lane of `ext_rdata` in the cycle its access is acknowledged. The bytes are returned in `rsp_rdata` in the same right-justified order, with the unused upper bytes at 0. `rsp_valid` rises in the cycle after the final `ext_ack`.
- R7: `ext_start` stays at 1, with `ext_addr`, `ext_size` and `ext_we` unchanged, until `ext_ack` is seen. The next access, if any, appears in the cycle after the acknowledge.
- R8: An inbound access is checked one cycle after `inb_valid`, with `inb_size` coded 0 = byte, 1 = halfword, 2 = word and 3 = burst (8-byte aligned). A misaligned access gives an `inb_err` pulse and no `inb_fwd`. An aligned one gives `inb_fwd` and no error. With no `inb_valid`, both stay 0.
- R9: Each request produces exactly one single-cycle `rsp_valid` pulse, and `ext_start` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port16 | input | 1 | 1 selects a 16-bit external port, 0 a 32-bit port; static |
| req_valid | input | 1 | Internal request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address of the first operand byte |
| req_len | input | 2 | Length minus one (0..3) |
| req_wdata | input | 32 | Right-justified write operand |
| rsp_valid | output | 1 | Single-cycle completion |
| rsp_rdata | output | 32 | Right-justified read operand |
| ext_start | output | 1 | External access request, held until ack |
| ext_ack | input | 1 | External access done |
| ext_addr | output | AW | Aligned container address |
| ext_size | output | 2 | 0 byte, 1 halfword, 2 word |
| ext_write | output | 1 | Access direction |
| ext_we | output | 4 | Active lane mask, bit i = lane i |
| ext_wdata | output | 32 | Write lanes, lane 0 in bits 31:24 |
| ext_rdata | input | 32 | Read lanes, lane 0 in bits 31:24 |
| inb_valid | input | 1 | Inbound external access present |
| inb_addr | input | AW | Inbound address |
| inb_size | input | 2 | Inbound size code |
| inb_fwd | output | 1 | Inbound access accepted for forwarding |
| inb_err | output | 1 | Inbound access rejected as misaligned |

## Verification
The assertions check in every cycle that an issued access is naturally aligned for its size and has a non-empty lane mask. They also check that a byte access enables a single lane and that a 16-bit port never touches lanes 2 and 3. The handshake properties are checked every cycle too: a request is held until acknowledged, no request is taken while an access is live, completions are single pulses that follow an acknowledge, and inbound error and forward are mutually exclusive. Only the bench sweep can show that the split is the right one. That covers the number and order of the pieces, the exact byte-to-lane mapping of write data, and read bytes being reassembled into the right operand positions. The bench also classifies every inbound address and size pair.

// File: rtl/misalign_pkg.sv
package misalign_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_BURST = 2'd3
    } xsize_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } mstate_e;
endpackage

// File: rtl/msplit_piece.sv
module msplit_piece
    import misalign_pkg::*;
#(
    parameter int NL = 4,
    localparam int LW = $clog2(NL)
) (
    input  logic          port16,
    input  logic [LW-1:0] cur_lo,
    input  logic [LW:0]   rem,
    output logic [LW-1:0] pos,
    output logic [LW:0]   cnt,
    output xsize_e        size,
    output logic [LW-1:0] lomask
);
    logic [LW:0] room;

    always_comb begin
        pos    = port16 ? {{(LW-1){1'b0}}, cur_lo[0]} : cur_lo;
        room   = port16 ? ((LW+1)'(2) - {1'b0, pos}) : ((LW+1)'(NL) - {1'b0, pos});
        cnt    = (rem < room) ? rem : room;
        if (cnt == (LW+1)'(1)) begin
            size   = SZ_BYTE;
            lomask = '0;
        end else if (port16 || (cnt == (LW+1)'(2) && !pos[0])) begin
            size   = SZ_HALF;
            lomask = LW'(1);
        end else begin
            size   = SZ_WORD;
            lomask = LW'(NL-1);
        end
    end
endmodule

// File: rtl/msplit_lanes.sv
module msplit_lanes #(
    parameter int DW = 32,
    localparam int NL = DW / 8,
    localparam int LW = $clog2(NL)
) (
    input  logic [LW-1:0] pos,
    input  logic [LW:0]   cnt,
    input  logic [LW-1:0] off,
    input  logic [LW-1:0] len,
    input  logic [DW-1:0] wd,
    input  logic [DW-1:0] rd,
    input  logic [DW-1:0] hold,
    output logic [NL-1:0] we,
    output logic [DW-1:0] lane_wd,
    output logic [DW-1:0] merged
);
    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [LW-1:0] rel;
        logic [LW-1:0] slot;
        logic          act;
        always_comb begin
            rel  = LW'(i) - pos;
            act  = (LW'(i) >= pos) && ({1'b0, rel} < cnt);
            slot = len - (off + rel);
            we[i] = act;
            lane_wd[DW-1-8*i -: 8] = act ? wd[{slot, 3'b000} +: 8] : 8'h00;
        end
    end

    for (genvar s = 0; s < NL; s++) begin : g_slot
        logic [LW-1:0] kk;
        logic [LW-1:0] lane;
        logic [LW-1:0] ridx;
        logic          inr;
        always_comb begin
            kk   = len - LW'(s);
            inr  = (LW'(s) <= len) && (kk >= off) && ({1'b0, kk - off} < cnt);
            lane = pos + (kk - off);
            ridx = LW'(NL-1) - lane;
            merged[8*s +: 8] = inr ? rd[{ridx, 3'b000} +: 8] : hold[8*s +: 8];
        end
    end
endmodule

// File: rtl/msplit_inb_chk.sv
module msplit_inb_chk
    import misalign_pkg::*;
(
    input  logic [2:0] addr_lo,
    input  xsize_e     size,
    output logic       mis
);
    always_comb begin
        unique case (size)
            SZ_BYTE:  mis = 1'b0;
            SZ_HALF:  mis = addr_lo[0];
            SZ_WORD:  mis = |addr_lo[1:0];
            default:  mis = |addr_lo;
        endcase
    end
endmodule

// File: rtl/misalign_split.sv
module misalign_split
    import misalign_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          port16,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_len,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          ext_start,
    input  logic          ext_ack,
    output logic [AW-1:0] ext_addr,
    output logic [1:0]    ext_size,
    output logic          ext_write,
    output logic [3:0]    ext_we,
    output logic [DW-1:0] ext_wdata,
    input  logic [DW-1:0] ext_rdata,
    input  logic          inb_valid,
    input  logic [AW-1:0] inb_addr,
    input  logic [1:0]    inb_size,
    output logic          inb_fwd,
    output logic          inb_err
);
    localparam int NL = DW / 8;
    localparam int LW = $clog2(NL);

    typedef struct packed {
        mstate_e       st;
        logic [AW-1:0] cur;
        logic [LW:0]   rem;
        logic [LW-1:0] off;
        logic [LW-1:0] len;
        logic          wr;
        logic [DW-1:0] wd;
        logic [DW-1:0] hold;
        logic          rsp;
        logic          ierr;
        logic          ifwd;
    } regs_t;

    regs_t q, d;

    logic [LW-1:0] pos;
    logic [LW:0]   cnt;
    xsize_e        psize;
    logic [LW-1:0] lomask;
    logic [NL-1:0] lane_we;
    logic [DW-1:0] lane_wd;
    logic [DW-1:0] merged;
    logic          inb_mis;

    msplit_piece #(.NL(NL)) u_piece (
        .port16 (port16),
        .cur_lo (q.cur[LW-1:0]),
        .rem    (q.rem),
        .pos    (pos),
        .cnt    (cnt),
        .size   (psize),
        .lomask (lomask)
    );

    msplit_lanes #(.DW(DW)) u_lanes (
        .pos     (pos),
        .cnt     (cnt),
        .off     (q.off),
        .len     (q.len),
        .wd      (q.wd),
        .rd      (ext_rdata),
        .hold    (q.hold),
        .we      (lane_we),
        .lane_wd (lane_wd),
        .merged  (merged)
    );

    msplit_inb_chk u_inb (
        .addr_lo (inb_addr[2:0]),
        .size    (xsize_e'(inb_size)),
        .mis     (inb_mis)
    );

    always_comb begin
        d      = q;
        d.rsp  = 1'b0;
        d.ierr = inb_valid && inb_mis;
        d.ifwd = inb_valid && !inb_mis;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st   = ST_BUSY;
                    d.cur  = req_addr;
                    d.rem  = {1'b0, req_len} + (LW+1)'(1);
                    d.off  = '0;
                    d.len  = req_len;
                    d.wr   = req_write;
                    d.wd   = req_wdata;
                    d.hold = '0;
                end
            end
            default: begin
                if (ext_ack) begin
                    if (!q.wr) d.hold = merged;
                    if (cnt == q.rem) begin
                        d.st  = ST_IDLE;
                        d.rsp = 1'b1;
                    end else begin
                        d.cur = q.cur + AW'(cnt);
                        d.rem = q.rem - cnt;
                        d.off = q.off + cnt[LW-1:0];
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rsp_valid = q.rsp;
    assign rsp_rdata = q.hold;
    assign ext_start = (q.st == ST_BUSY);
    assign ext_addr  = q.cur & ~AW'(lomask);
    assign ext_size  = psize;
    assign ext_write = q.wr;
    assign ext_we    = lane_we;
    assign ext_wdata = q.wr ? lane_wd : '0;
    assign inb_fwd   = q.ifwd;
    assign inb_err   = q.ierr;
endmodule

// File: rtl/misalign_split_chk.sv
module misalign_split_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          port16,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          ext_start,
    input logic          ext_ack,
    input logic [AW-1:0] ext_addr,
    input logic [1:0]    ext_size,
    input logic [3:0]    ext_we,
    input logic          inb_valid,
    input logic          inb_fwd,
    input logic          inb_err
);
    a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && ext_start));

    a_r3_half_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_start && ext_size == 2'd1) |-> !ext_addr[0]);

    a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_start && ext_size == 2'd2) |-> (ext_addr[1:0] == 2'b00));

    a_r4_narrow_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_start && port16) |-> (ext_we[3:2] == 2'b00 && ext_size != 2'd2));

    a_r5_some_lane: assert property (@(posedge clk) disable iff (!rst_n)
        ext_start |-> (ext_we != 4'b0000));

    a_r5_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_start && ext_size == 2'd0) |-> ($countones(ext_we) == 1));

    a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_start && !ext_ack) |=> (ext_start && $stable(ext_addr) && $stable(ext_we) && $stable(ext_size)));

    a_r6_rsp_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(ext_ack) && $past(ext_start)));

    a_r9_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r9_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !ext_start);

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(inb_err && inb_fwd));

    a_r8_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (inb_err || inb_fwd) |-> $past(inb_valid));
endmodule

bind misalign_split misalign_split_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .port16    (port16),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .ext_start (ext_start),
    .ext_ack   (ext_ack),
    .ext_addr  (ext_addr),
    .ext_size  (ext_size),
    .ext_we    (ext_we),
    .inb_valid (inb_valid),
    .inb_fwd   (inb_fwd),
    .inb_err   (inb_err)
);

// File: tb/misalign_split_tb.sv
module misalign_split_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port16 = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_len = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        ext_start;
    logic        ext_ack = 1'b0;
    logic [31:0] ext_addr;
    logic [1:0]  ext_size;
    logic        ext_write;
    logic [3:0]  ext_we;
    logic [31:0] ext_wdata;
    logic [31:0] ext_rdata = '0;
    logic        inb_valid = 1'b0;
    logic [31:0] inb_addr = '0;
    logic [1:0]  inb_size = '0;
    logic        inb_fwd;
    logic        inb_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    misalign_split u_dut (
        .clk(clk), .rst_n(rst_n), .port16(port16),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ext_start(ext_start), .ext_ack(ext_ack), .ext_addr(ext_addr),
        .ext_size(ext_size), .ext_write(ext_write), .ext_we(ext_we),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .inb_valid(inb_valid), .inb_addr(inb_addr), .inb_size(inb_size),
        .inb_fwd(inb_fwd), .inb_err(inb_err)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ 8'h96 ^ {a[11:8], a[3:0]};
    endfunction

    task automatic run_req(input bit p16, input bit wr, input int len, input logic [31:0] addr);
        int n;
        int cw;
        int np;
        int first[4];
        int cnt[4];
        logic [31:0] wd;
        logic [31:0] exp_rd;
        string rq;
        n  = len + 1;
        cw = p16 ? 2 : 4;
        rq = p16 ? "R4" : "R3";
        wd = 32'hC35A_A53C ^ (addr * 32'h0101_0101);
        np = 0;
        for (int k = 0; k < n; k++) begin
            logic [31:0] a;
            a = addr + k;
            if (k == 0 || (a / cw) != ((a - 1) / cw)) begin
                first[np] = k;
                cnt[np]   = 0;
                np++;
            end
            cnt[np-1]++;
        end
        exp_rd = '0;
        for (int k = 0; k < n; k++) exp_rd |= 32'(mem_byte(addr + k)) << (8 * (n - 1 - k));

        @(negedge clk);
        port16 = p16; req_write = wr; req_addr = addr; req_len = 2'(len); req_wdata = wd;
        req_valid = 1'b1;
        chk("R2", "ready before take", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "ready while busy", 32'(req_ready), 32'd0);

        for (int p = 0; p < np; p++) begin
            logic [31:0] fa;
            logic [31:0] la;
            logic [31:0] e_addr;
            logic [1:0]  e_size;
            logic [3:0]  e_we;
            logic [31:0] e_wd;
            logic [31:0] base;
            logic [31:0] rdv;
            fa = addr + first[p];
            la = fa + cnt[p] - 1;
            if (cnt[p] == 1) begin
                e_size = 2'd0; e_addr = fa;
            end else if ((fa >> 1) == (la >> 1)) begin
                e_size = 2'd1; e_addr = fa & ~32'd1;
            end else begin
                e_size = 2'd2; e_addr = fa & ~32'd3;
            end
            e_we = '0;
            e_wd = '0;
            for (int j = 0; j < cnt[p]; j++) begin
                int ln;
                int k;
                ln = (fa + j) % cw;
                k  = first[p] + j;
                e_we[ln] = 1'b1;
                e_wd |= 32'((wd >> (8 * (n - 1 - k))) & 32'hFF) << (8 * (3 - ln));
            end
            base = fa - (fa % cw);
            rdv = '0;
            for (int i = 0; i < 4; i++) begin
                logic [7:0] bv;
                bv = (i < cw) ? mem_byte(base + i) : 8'hEE;
                rdv |= 32'(bv) << (8 * (3 - i));
            end
            chk("R7", "start raised", 32'(ext_start), 32'd1);
            chk(rq, "access address", ext_addr, e_addr);
            chk(rq, "access size", 32'(ext_size), 32'(e_size));
            chk("R5", "lane mask", 32'(ext_we), 32'(e_we));
            chk("R5", "direction", 32'(ext_write), 32'(wr));
            if (wr) chk("R5", "write lanes", ext_wdata, e_wd);
            ext_rdata = rdv;
            if (((p + addr) & 1) != 0) begin
                @(negedge clk);
                chk("R7", "start held", 32'(ext_start), 32'd1);
                chk("R7", "address held", ext_addr, e_addr);
            end
            ext_ack = 1'b1;
            @(negedge clk);
            ext_ack = 1'b0;
        end
        chk("R9", "completion pulse", 32'(rsp_valid), 32'd1);
        chk("R9", "no access at completion", 32'(ext_start), 32'd0);
        if (!wr) chk("R6", "read operand", rsp_rdata, exp_rd);
        @(negedge clk);
        chk("R9", "completion single", 32'(rsp_valid), 32'd0);
        chk("R2", "ready after completion", 32'(req_ready), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "ready in reset", 32'(req_ready), 32'd1);
        chk("R1", "start in reset", 32'(ext_start), 32'd0);
        chk("R1", "rsp in reset", 32'(rsp_valid), 32'd0);
        chk("R1", "inbound in reset", {30'd0, inb_err, inb_fwd}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after reset", 32'(req_ready), 32'd1);
        chk("R1", "start after reset", 32'(ext_start), 32'd0);
        chk("R1", "rsp after reset", 32'(rsp_valid), 32'd0);

        for (int p16 = 0; p16 < 2; p16++)
            for (int wr = 0; wr < 2; wr++)
                for (int len = 0; len < 4; len++)
                    for (int lo = 0; lo < 8; lo++)
                        run_req(p16[0], wr[0], len,
                                32'h2000_0000 + 32'((p16 * 64 + wr * 32 + len * 8) << 4) + 32'(lo));

        for (int sz = 0; sz < 4; sz++)
            for (int lo = 0; lo < 16; lo++) begin
                bit mis;
                mis = (lo % (1 << (sz == 3 ? 3 : sz))) != 0;
                @(negedge clk);
                inb_valid = 1'b1;
                inb_size  = 2'(sz);
                inb_addr  = 32'h4000_0100 + 32'(lo);
                @(negedge clk);
                inb_valid = 1'b0;
                chk("R8", "inbound error", 32'(inb_err), 32'(mis));
                chk("R8", "inbound forward", 32'(inb_fwd), 32'(!mis));
                @(negedge clk);
                chk("R8", "inbound quiet", {30'd0, inb_err, inb_fwd}, 32'd0);
            end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule